// File: doc/BRIEF.md
# Character-Cell CRT Timing Controller

This block produces raster timing for a character-mapped display. It works only in whole character cells and runs on the character clock. A column counter, a scanline-in-row counter and a character-row counter step through the frame. They produce the horizontal and vertical sync, a display-enable window, the refresh address into screen memory, and the scanline number within the current character row. The block has no notion of pixels, colour or text versus graphics. The logic downstream decides how to read the memory word at each address.

Software programs the geometry through two write ports that share one data bus. One write selects a register index, and the next write stores a value into the selected register. Every geometry register is live. Each one is compared by equality against its running counter, so a write made mid-frame takes effect as soon as that counter next reaches the new value. A value the counter has already passed waits until the next wrap. The screen start address is the exception: it is copied into the address counter only when a frame restarts.

Top module: `crtc_timing`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata[4:0]` as the register index. A write with `bus_sel`=1 stores the data into the indexed register, and the index stays selected for later data writes. The mapped indices are:
  - 0: horizontal total
  - 1: horizontal displayed
  - 2: hsync position
  - 3: hsync width, in bits 3:0
  - 4: vertical total
  - 5: vertical adjust
  - 6: vertical displayed
  - 7: vsync row
  - 9: last scanline
  - 12: start address high, in bits 5:0
  - 13: start address low

  Data writes to any other index change nothing.
- R2: The column counter runs from 0 up to the horizontal total and then wraps to 0. `hsync` rises one clock after the column equals the hsync position and stays high for the width in clocks. A width of 0 gives no pulse by default.
- R3: If the hsync position is greater than the horizontal total, the column never matches it and `hsync` stays low.
- R4: `disp_en` is high while the column is below the horizontal-displayed value and the row is below the vertical-displayed value, outside the adjust lines. With a horizontal total of 0, every line is one clock long and can still show one enabled cell.
- R5: `row_addr` counts from 0 up to the last-scanline value. On that scanline's line end it returns to 0 and the row counter advances.
- R6: After the last scanline of the row that equals the vertical total, the block inserts as many extra lines as the vertical adjust value. During these lines `row_addr` counts 0 upward and `disp_en` stays low. The frame then restarts at row 0. An adjust value of 0 restarts the frame at once.
- R7: `vsync` rises at column 0 of scanline 0 of the row that equals the vsync row value. It lasts VS_LINES scanlines.
- R8: `mem_addr` advances by one each clock and wraps modulo 2^14. Each line reloads the row base. The next row base is the address seen at the column equal to the horizontal-displayed value. If that column is never reached, the row base is unchanged.
- R9: `mem_addr` takes the start address {high, low} only at frame restart. A start-address write made mid-frame first shows at the next frame.
- R10: While `rst_n` is low, all registers and counters are zero. In that state `hsync`, `vsync` and `disp_en` are low, and `mem_addr` and `row_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | character clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_we | input | 1 | register write strobe |
| bus_sel | input | 1 | 0 selects the index, 1 writes the data |
| bus_wdata | input | 8 | write data |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| disp_en | output | 1 | display enable |
| mem_addr | output | 14 | refresh address |
| row_addr | output | 5 | scanline within the character row |

## Verification
The bench builds the block with VS_LINES set to 4 and every other parameter at its default. The short sync lets the vertical pulse fit inside frames of only 7 to 21 lines, so a full frame can be compared cycle by cycle in a few hundred clocks. The default 14-bit address makes a start address just below the top reachable, which exercises the address wrap. The default width-0 rule keeps the hsync width field literal. One frame uses a horizontal total of 0, which reaches the one-clock-line corner and sync suppression together.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
   localparam int IDX_W = 5;
   typedef logic [IDX_W-1:0] crtc_idx_t;

   localparam crtc_idx_t IX_HTOT     = 5'd0;
   localparam crtc_idx_t IX_HDISP    = 5'd1;
   localparam crtc_idx_t IX_HSPOS    = 5'd2;
   localparam crtc_idx_t IX_SYNCW    = 5'd3;
   localparam crtc_idx_t IX_VTOT     = 5'd4;
   localparam crtc_idx_t IX_VADJ     = 5'd5;
   localparam crtc_idx_t IX_VDISP    = 5'd6;
   localparam crtc_idx_t IX_VSROW    = 5'd7;
   localparam crtc_idx_t IX_LASTSCAN = 5'd9;
   localparam crtc_idx_t IX_START_HI = 5'd12;
   localparam crtc_idx_t IX_START_LO = 5'd13;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
   import crtc_pkg::*;
#(
   parameter int D_W   = 8,
   parameter int H_W   = 8,
   parameter int V_W   = 7,
   parameter int S_W   = 5,
   parameter int A_W   = 14,
   parameter int HSW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic             bus_sel,
   input  logic [D_W-1:0]   bus_wdata,
   output logic [H_W-1:0]   h_total,
   output logic [H_W-1:0]   h_disp,
   output logic [H_W-1:0]   hs_pos,
   output logic [HSW_W-1:0] hs_width,
   output logic [V_W-1:0]   v_total,
   output logic [S_W-1:0]   v_adj,
   output logic [V_W-1:0]   v_disp,
   output logic [V_W-1:0]   vs_row,
   output logic [S_W-1:0]   last_scan,
   output logic [A_W-1:0]   start_addr
);
   localparam int HI_W = A_W - D_W;

   generate
      if (H_W > D_W || V_W > D_W || S_W > D_W || HSW_W > D_W) begin : g_bad_width
         $error("crtc_regs: a field is wider than the data bus");
      end
      if (HI_W < 1 || HI_W > D_W) begin : g_bad_addr
         $error("crtc_regs: address must span more than one and at most two data words");
      end
      if (IDX_W > D_W) begin : g_bad_idx
         $error("crtc_regs: index wider than the data bus");
      end
   endgenerate

   crtc_idx_t        sel_idx;
   logic [HI_W-1:0]  start_hi;
   logic [D_W-1:0]   start_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_idx   <= '0;
         h_total   <= '0;
         h_disp    <= '0;
         hs_pos    <= '0;
         hs_width  <= '0;
         v_total   <= '0;
         v_adj     <= '0;
         v_disp    <= '0;
         vs_row    <= '0;
         last_scan <= '0;
         start_hi  <= '0;
         start_lo  <= '0;
      end else if (bus_we && !bus_sel) begin
         sel_idx <= bus_wdata[IDX_W-1:0];
      end else if (bus_we && bus_sel) begin
         case (sel_idx)
            IX_HTOT:     h_total   <= bus_wdata[H_W-1:0];
            IX_HDISP:    h_disp    <= bus_wdata[H_W-1:0];
            IX_HSPOS:    hs_pos    <= bus_wdata[H_W-1:0];
            IX_SYNCW:    hs_width  <= bus_wdata[HSW_W-1:0];
            IX_VTOT:     v_total   <= bus_wdata[V_W-1:0];
            IX_VADJ:     v_adj     <= bus_wdata[S_W-1:0];
            IX_VDISP:    v_disp    <= bus_wdata[V_W-1:0];
            IX_VSROW:    vs_row    <= bus_wdata[V_W-1:0];
            IX_LASTSCAN: last_scan <= bus_wdata[S_W-1:0];
            IX_START_HI: start_hi  <= bus_wdata[HI_W-1:0];
            IX_START_LO: start_lo  <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign start_addr = {start_hi, start_lo};

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_sel) |=> sel_idx == $past(sel_idx)) else $error("index changed on data write"); // R1
endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount #(
   parameter int H_W          = 8,
   parameter int HSW_W        = 4,
   parameter bit HS_ZERO_FULL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [H_W-1:0]   h_total,
   input  logic [H_W-1:0]   hs_pos,
   input  logic [HSW_W-1:0] hs_width,
   output logic [H_W-1:0]   col,
   output logic             line_end,
   output logic             hsync
);
   localparam int CNT_W = HSW_W + 1;

   generate
      if (H_W < 2 || HSW_W < 1) begin : g_bad_param
         $error("crtc_hcount: widths too small");
      end
   endgenerate

   logic [CNT_W-1:0] hs_left;
   logic [CNT_W-1:0] hs_load;

   generate
      if (HS_ZERO_FULL) begin : g_zero_full
         assign hs_load = (hs_width == '0) ? {1'b1, {HSW_W{1'b0}}} : {1'b0, hs_width};
      end else begin : g_zero_none
         assign hs_load = {1'b0, hs_width};
      end
   endgenerate

   assign line_end = (col == h_total);
   assign hsync    = (hs_left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
      end else if (line_end) begin
         col <= '0;
      end else begin
         col <= col + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_left <= '0;
      end else if (col == hs_pos) begin
         hs_left <= hs_load;
      end else if (hs_left != '0) begin
         hs_left <= hs_left - 1'b1;
      end
   end

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !line_end |=> col == $past(col) + 1'b1) else $error("column skipped"); // R2
   AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |=> col == '0) else $error("column did not wrap"); // R2
   AST_HS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |-> $past(col) == $past(hs_pos)) else $error("hsync rose off position"); // R2
   AST_HS_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_pos > h_total && col <= h_total && !hsync) |=> !hsync) else $error("hsync past total"); // R3
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount #(
   parameter int V_W      = 7,
   parameter int S_W      = 5,
   parameter int VS_LINES = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_end,
   input  logic [V_W-1:0] v_total,
   input  logic [S_W-1:0] v_adj,
   input  logic [V_W-1:0] v_disp,
   input  logic [V_W-1:0] vs_row,
   input  logic [S_W-1:0] last_scan,
   output logic [S_W-1:0] scan,
   output logic           in_adjust,
   output logic           row_end,
   output logic           frame_restart,
   output logic           row_visible,
   output logic           vsync
);
   localparam int VC_W = $clog2(VS_LINES + 1);

   generate
      if (VS_LINES < 1) begin : g_bad_vs
         $error("crtc_vcount: VS_LINES must be at least 1");
      end
   endgenerate

   logic [V_W-1:0]  row;
   logic [V_W-1:0]  next_row;
   logic [VC_W-1:0] vs_left;
   logic            row_last;
   logic            adj_last;
   logic            at_vtotal;
   logic            enter_adj;
   logic            new_row;

   assign row_last      = (scan == last_scan) && !in_adjust;
   assign adj_last      = in_adjust && ((scan + 1'b1) == v_adj);
   assign at_vtotal     = row_last && (row == v_total);
   assign row_end       = line_end && row_last;
   assign frame_restart = line_end && ((at_vtotal && v_adj == '0) || adj_last);
   assign enter_adj     = line_end && at_vtotal && (v_adj != '0);
   assign new_row       = frame_restart || (row_end && !enter_adj);
   assign next_row      = frame_restart ? '0 : row + 1'b1;
   assign row_visible   = (row < v_disp) && !in_adjust;
   assign vsync         = (vs_left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan      <= '0;
         row       <= '0;
         in_adjust <= 1'b0;
      end else if (line_end) begin
         if (frame_restart) begin
            scan      <= '0;
            row       <= '0;
            in_adjust <= 1'b0;
         end else if (enter_adj) begin
            scan      <= '0;
            row       <= row + 1'b1;
            in_adjust <= 1'b1;
         end else if (row_last) begin
            scan <= '0;
            row  <= row + 1'b1;
         end else begin
            scan <= scan + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_left <= '0;
      end else if (new_row && next_row == vs_row) begin
         vs_left <= VC_W'(VS_LINES);
      end else if (line_end && vs_left != '0) begin
         vs_left <= vs_left - 1'b1;
      end
   end

   AST_VS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync) |-> (scan == '0 && !in_adjust)) else $error("vsync off row start"); // R7
   AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      row_end |=> scan == '0) else $error("scan did not wrap"); // R5
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      frame_restart |=> (scan == '0 && !in_adjust && row_visible == (v_disp != '0))) else $error("bad restart"); // R6
endmodule

// File: rtl/crtc_maddr.sv
module crtc_maddr #(
   parameter int A_W = 14,
   parameter int H_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [H_W-1:0] col,
   input  logic [H_W-1:0] h_disp,
   input  logic           line_end,
   input  logic           row_end,
   input  logic           frame_restart,
   input  logic [A_W-1:0] start_addr,
   output logic [A_W-1:0] ma
);
   generate
      if (A_W < 2) begin : g_bad_aw
         $error("crtc_maddr: address too narrow");
      end
   endgenerate

   logic [A_W-1:0] row_base;
   logic [A_W-1:0] next_base;
   logic [A_W-1:0] next_base_now;
   logic           capture;

   assign capture       = (col == h_disp);
   assign next_base_now = capture ? ma : next_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma        <= '0;
         row_base  <= '0;
         next_base <= '0;
      end else if (frame_restart) begin
         ma        <= start_addr;
         row_base  <= start_addr;
         next_base <= start_addr;
      end else if (line_end && row_end) begin
         ma        <= next_base_now;
         row_base  <= next_base_now;
         next_base <= next_base_now;
      end else begin
         ma        <= line_end ? row_base : ma + 1'b1;
         next_base <= next_base_now;
      end
   end

   AST_MA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !line_end |=> ma == $past(ma) + 1'b1) else $error("address did not step"); // R8
   AST_MA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_restart |=> ma == $past(start_addr)) else $error("start not loaded"); // R9
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing #(
   parameter int D_W          = 8,
   parameter int H_W          = 8,
   parameter int V_W          = 7,
   parameter int S_W          = 5,
   parameter int A_W          = 14,
   parameter int HSW_W        = 4,
   parameter int VS_LINES     = 16,
   parameter bit HS_ZERO_FULL = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_we,
   input  logic           bus_sel,
   input  logic [D_W-1:0] bus_wdata,
   output logic           hsync,
   output logic           vsync,
   output logic           disp_en,
   output logic [A_W-1:0] mem_addr,
   output logic [S_W-1:0] row_addr
);
   logic [H_W-1:0]   h_total, h_disp, hs_pos, col;
   logic [HSW_W-1:0] hs_width;
   logic [V_W-1:0]   v_total, v_disp, vs_row;
   logic [S_W-1:0]   v_adj, last_scan;
   logic [A_W-1:0]   start_addr;
   logic             line_end, in_adjust, row_end, frame_restart, row_visible;

   crtc_regs #(.D_W(D_W), .H_W(H_W), .V_W(V_W), .S_W(S_W), .A_W(A_W), .HSW_W(HSW_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos), .hs_width(hs_width),
      .v_total(v_total), .v_adj(v_adj), .v_disp(v_disp), .vs_row(vs_row),
      .last_scan(last_scan), .start_addr(start_addr)
   );

   crtc_hcount #(.H_W(H_W), .HSW_W(HSW_W), .HS_ZERO_FULL(HS_ZERO_FULL)) u_h (
      .clk(clk), .rst_n(rst_n), .h_total(h_total), .hs_pos(hs_pos), .hs_width(hs_width),
      .col(col), .line_end(line_end), .hsync(hsync)
   );

   crtc_vcount #(.V_W(V_W), .S_W(S_W), .VS_LINES(VS_LINES)) u_v (
      .clk(clk), .rst_n(rst_n), .line_end(line_end), .v_total(v_total), .v_adj(v_adj),
      .v_disp(v_disp), .vs_row(vs_row), .last_scan(last_scan), .scan(row_addr),
      .in_adjust(in_adjust), .row_end(row_end), .frame_restart(frame_restart),
      .row_visible(row_visible), .vsync(vsync)
   );

   crtc_maddr #(.A_W(A_W), .H_W(H_W)) u_ma (
      .clk(clk), .rst_n(rst_n), .col(col), .h_disp(h_disp), .line_end(line_end),
      .row_end(row_end), .frame_restart(frame_restart), .start_addr(start_addr), .ma(mem_addr)
   );

   assign disp_en = (col < h_disp) && row_visible;

   AST_DE_ADJUST: assert property (@(posedge clk) disable iff (!rst_n)
      in_adjust |-> !disp_en) else $error("display during adjust"); // R6
   AST_DE_LATE_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && h_disp <= h_total) |-> !disp_en) else $error("display at line end"); // R4
endmodule

// File: tb/crtc_timing_test.sv
module crtc_timing_test;
   localparam int VS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_sel = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        hsync, vsync, disp_en;
   logic [13:0] mem_addr;
   logic [4:0]  row_addr;

   always #2 clk = ~clk;

   crtc_timing #(.VS_LINES(VS)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .mem_addr(mem_addr), .row_addr(row_addr)
   );

   typedef struct {
      logic        hs;
      logic        vs;
      logic        de;
      logic [13:0] ma;
      logic [4:0]  ra;
   } exp_t;

   exp_t  expq[$];
   int    n_tests = 0;
   int    n_fail  = 0;
   bit    armed   = 1'b0;
   bit    synced  = 1'b0;
   logic  prev_vs = 1'b0;
   string hs_req  = "R2";

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // monitor: compare the stream from the first vsync rise
   always @(negedge clk) begin
      exp_t it;
      if (armed) begin
         if (!synced && vsync && !prev_vs) synced = 1'b1;
         if (synced && expq.size() > 0) begin
            it = expq.pop_front();
            check(hs_req, "hsync",    int'(hsync),    int'(it.hs));
            check("R7",   "vsync",    int'(vsync),    int'(it.vs));
            check("R4",   "disp_en",  int'(disp_en),  int'(it.de));
            check("R8",   "mem_addr", int'(mem_addr), int'(it.ma));
            check("R5",   "row_addr", int'(row_addr), int'(it.ra));
            if (expq.size() == 0) begin
               armed  = 1'b0;
               synced = 1'b0;
            end
         end
      end
      prev_vs = vsync;
   end

   task automatic bus_index(input int idx);
      @(negedge clk); bus_we = 1'b1; bus_sel = 1'b0; bus_wdata = 8'(idx);
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic bus_data(input int val);
      @(negedge clk); bus_we = 1'b1; bus_sel = 1'b1; bus_wdata = 8'(val);
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic reg_write(input int idx, input int val);
      @(negedge clk); bus_we = 1'b1; bus_sel = 1'b0; bus_wdata = 8'(idx);
      @(negedge clk); bus_sel = 1'b1; bus_wdata = 8'(val);
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic setup(input int ht, hd, hp, r3, vt, adj, vd, vp, ms, start);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      reg_write(12, (start >> 8) & 8'h3F);
      reg_write(13, start & 8'hFF);
      reg_write(0, ht); reg_write(1, hd); reg_write(2, hp); reg_write(3, r3);
      reg_write(4, vt); reg_write(5, adj); reg_write(6, vd); reg_write(7, vp);
      reg_write(9, ms);
   endtask

   // driver: push one whole frame, starting at the vsync line
   task automatic run_frame(input int ht, hd, hp, w, vt, adj, vd, vp, ms, start);
      int lpr = ms + 1;
      int nrm = (vt + 1) * lpr;
      int tot = nrm + adj;
      int vsl = vp * lpr;
      for (int k = 0; k < tot; k++) begin
         int L = (vsl + k) % tot;
         int row, ra;
         bit adjf;
         if (L < nrm) begin row = L / lpr; ra = L % lpr; adjf = 1'b0; end
         else begin row = vt + 1; ra = L - nrm; adjf = 1'b1; end
         for (int c = 0; c <= ht; c++) begin
            exp_t it;
            it.de = (c < hd) && (row < vd) && !adjf;
            it.ma = 14'((hd <= ht) ? (start + row * hd + c) : (start + c));
            it.ra = 5'(ra);
            it.hs = (hp <= ht) && (w != 0) && (c > hp) && (c <= hp + w);
            it.vs = (k < VS);
            expq.push_back(it);
         end
      end
      armed = 1'b1;
      wait (armed == 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R10: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (2) @(negedge clk);
      check("R10", "hsync",    int'(hsync),    0);
      check("R10", "vsync",    int'(vsync),    0);
      check("R10", "disp_en",  int'(disp_en),  0);
      check("R10", "mem_addr", int'(mem_addr), 0);
      check("R10", "row_addr", int'(row_addr), 0);

      // frame A: adjust lines (R6), width in low nibble only (R2)
      setup(9, 6, 7, 8'hF2, 4, 2, 3, 3, 1, 14'h0123);
      hs_req = "R2";
      run_frame(9, 6, 7, 2, 4, 2, 3, 3, 1, 14'h0123);

      // frame B: three scanlines per row, address wrap (R8), unmapped writes (R1)
      setup(13, 8, 10, 3, 6, 0, 2, 5, 2, 14'h3FF0);
      reg_write(8, 8'h55); reg_write(14, 8'h11); reg_write(15, 8'h77); reg_write(20, 8'h01);
      bus_index(6); bus_data(2); bus_data(5);   // R1: index held across data writes
      run_frame(13, 8, 10, 3, 6, 0, 5, 5, 2, 14'h3FF0);

      // frame C: total of 0, sync position beyond total (R3, R4)
      setup(0, 1, 5, 2, 2, 1, 2, 0, 1, 14'h0200);
      hs_req = "R3";
      run_frame(0, 1, 5, 2, 2, 1, 2, 0, 1, 14'h0200);
      hs_req = "R2";

      // R9: start address written mid-frame shows only next frame
      setup(9, 6, 7, 2, 4, 2, 3, 3, 1, 14'h0123);
      begin
         logic pv = 1'b1;
         forever begin
            @(negedge clk);
            if (vsync && !pv) break;
            pv = vsync;
         end
      end
      reg_write(12, 8'h04);
      reg_write(13, 8'h56);
      repeat (14) @(negedge clk);
      check("R9", "mem_addr mid-frame", int'(mem_addr), 14'h013B);
      check("R9", "row_addr mid-frame", int'(row_addr), 0);
      repeat (40) @(negedge clk);
      check("R9", "mem_addr next frame", int'(mem_addr), 14'h0456);
      check("R9", "disp_en next frame",  int'(disp_en),  1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule